// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM that has a 4-bit data bus, two active-low chip selects, an active-low write enable and an active-low output enable. The host gives it one request at a time through a valid/ready handshake. Each request carries an address, write data and a write flag. The sequencer then drives the RAM pins through a fixed, clock-counted sequence. A read returns its data to the host with a single-cycle valid pulse.

Every RAM timing figure is supplied in nanoseconds together with the clock period. The block turns these into clock-cycle counts when it is elaborated. The access wait, the write strobe length and the setup and recovery phases all come from those counts.

During a write the output enable is kept high. This lets the shorter strobe rule apply. The host data driver is switched on only after the RAM's outputs have had a cycle to turn off.

The pad drivers sit outside the block. It presents the outgoing data, a drive enable and the incoming data as three separate ports.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `req_ready` is 1, both chip selects, write enable and output enable are 1 (inactive), and `mem_dq_oe` is 0.
- R2: `mem_cs1_n` and `mem_cs2_n` always carry the same value.
- R3: A read holds the chip selects at 0, write enable at 1 and output enable at 0 for exactly ACC cycles, where ACC = ceil(T_ACC_NS / CLK_NS). `rsp_rdata` equals the RAM data sampled at the clock edge that ends that window. `mem_dq_oe` is never 1 while output enable is 0.
- R4: `rsp_valid` is high for exactly one cycle. This cycle is the (SETUP_CYC + ACC + 1)-th cycle after the edge at which the read request was accepted.
- R5: A write holds output enable at 1 for its whole duration. Write enable is only ever 0 while both chip selects are 0.
- R6: `mem_addr` never changes between two consecutive cycles in which the chip selects are both 0. This also covers every cycle in which write enable is 0.
- R7: `mem_dq_oe` rises one cycle after write enable falls, never in the cycle write enable falls. It stays high for PULSE cycles in total, ending one cycle after write enable rises.
- R8: A request is accepted only at an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access ends. For a write, `req_ready` returns in the (SETUP_CYC + PULSE + RECOVER_CYC + 1)-th cycle after acceptance.
- R9: The write strobe lasts PULSE = max(ceil(T_WP_NS / CLK_NS), ceil(T_DW_NS / CLK_NS) + 1, 2) cycles.
- R10: Data written to an address is returned by any later read of that address, across the full address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse marking valid read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_cs1_n | output | 1 | RAM chip select, first (active low) |
| mem_cs2_n | output | 1 | RAM chip select, second (active low) |
| mem_we_n | output | 1 | RAM write enable (active low) |
| mem_oe_n | output | 1 | RAM output enable (active low) |
| mem_dq_o | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | DATA_W | Data from the RAM pads |

## Verification
The case hardest to reach from the ports is a capture that happens too early: with an ideal RAM model, a sequencer that samples after fewer than ACC cycles still returns correct data. The bench therefore models a RAM that returns unknown values until it has been selected for ACC - 1 full cycles, so an early sample shows up as a miscompare. A passive pin monitor measures the strobe, drive-enable and output-enable run lengths on every access. It runs through two full write/read sweeps of a 64-word configuration, one in ascending and one in descending address order, with different data patterns.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } seq_state_e;

endpackage

// File: rtl/sram_phase_len.sv
// Last count value (length - 1) of each timed phase of the sequencer.
module sram_phase_len
    import sram_seq_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int ACC_CYC     = 4,
    parameter int PULSE_CYC   = 4,
    parameter int RECOVER_CYC = 1,
    parameter int CNT_W       = 3
) (
    input  seq_state_e       st,
    output logic [CNT_W-1:0] last
);

    always_comb begin
        case (st)
            ST_RD_SETUP,
            ST_WR_SETUP:   last = CNT_W'(SETUP_CYC - 1);
            ST_RD_WAIT:    last = CNT_W'(ACC_CYC - 1);
            ST_WR_PULSE:   last = CNT_W'(PULSE_CYC - 1);
            ST_WR_RECOVER: last = CNT_W'(RECOVER_CYC - 1);
            default:       last = '0;
        endcase
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
// Turns single host requests into timed pin sequences for an async SRAM.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 4,
    parameter int CLK_NS      = 5,
    parameter int T_ACC_NS    = 20,
    parameter int T_WP_NS     = 17,
    parameter int T_DW_NS     = 10,
    parameter int SETUP_CYC   = 1,
    parameter int RECOVER_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // Cycle counts derived from the nanosecond figures.
    localparam int ACC_RAW   = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
    localparam int ACC_CYC   = (ACC_RAW < 1) ? 1 : ACC_RAW;
    localparam int WP_CYC    = (T_WP_NS + CLK_NS - 1) / CLK_NS;
    localparam int DW_CYC    = (T_DW_NS + CLK_NS - 1) / CLK_NS + 1;
    localparam int PULSE_RAW = (WP_CYC > DW_CYC) ? WP_CYC : DW_CYC;
    localparam int PULSE_CYC = (PULSE_RAW < 2) ? 2 : PULSE_RAW;
    localparam int LONG_A    = (SETUP_CYC > ACC_CYC) ? SETUP_CYC : ACC_CYC;
    localparam int LONG_B    = (PULSE_CYC > RECOVER_CYC) ? PULSE_CYC : RECOVER_CYC;
    localparam int LONGEST   = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int CNT_W     = $clog2(LONGEST + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ready;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:     ST_IDLE,
        cnt:    '0,
        addr:   '0,
        wdata:  '0,
        rdata:  '0,
        rvalid: 1'b0,
        ready:  1'b1,
        cs_n:   1'b1,
        we_n:   1'b1,
        oe_n:   1'b1,
        dq_oe:  1'b0
    };

    ctl_t             ctl_q, ctl_d;
    logic [CNT_W-1:0] phase_last;
    logic             phase_end;

    sram_phase_len #(
        .SETUP_CYC   (SETUP_CYC),
        .ACC_CYC     (ACC_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .RECOVER_CYC (RECOVER_CYC),
        .CNT_W       (CNT_W)
    ) u_phase_len (
        .st   (ctl_q.st),
        .last (phase_last)
    );

    assign phase_end = (ctl_q.cnt == phase_last);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cnt = phase_end ? '0 : ctl_q.cnt + 1'b1;

        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.cnt = '0;
                if (req_valid && ctl_q.ready) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.st    = req_write ? ST_WR_SETUP : ST_RD_SETUP;
                end
            end
            ST_RD_SETUP:   if (phase_end) ctl_d.st = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (phase_end) begin
                    ctl_d.st    = ST_RD_CAPTURE;
                    ctl_d.rdata = mem_dq_i;
                end
            end
            ST_RD_CAPTURE: ctl_d.st = ST_IDLE;
            ST_WR_SETUP:   if (phase_end) ctl_d.st = ST_WR_PULSE;
            ST_WR_PULSE:   if (phase_end) ctl_d.st = ST_WR_RECOVER;
            ST_WR_RECOVER: if (phase_end) ctl_d.st = ST_IDLE;
            default:       ctl_d.st = ST_IDLE;
        endcase

        // Pin levels follow the state being entered, so they are registered.
        ctl_d.ready  = (ctl_d.st == ST_IDLE);
        ctl_d.rvalid = (ctl_d.st == ST_RD_CAPTURE);
        ctl_d.cs_n   = !(ctl_d.st inside {ST_RD_WAIT, ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER});
        ctl_d.oe_n   = (ctl_d.st != ST_RD_WAIT);
        ctl_d.we_n   = (ctl_d.st != ST_WR_PULSE);
        // Drive data from the second strobe cycle through the first recovery cycle.
        ctl_d.dq_oe  = (ctl_q.st == ST_WR_PULSE) &&
                       (ctl_d.st == ST_WR_PULSE || ctl_d.st == ST_WR_RECOVER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign req_ready = ctl_q.ready;
    assign rsp_valid = ctl_q.rvalid;
    assign rsp_rdata = ctl_q.rdata;
    assign mem_addr  = ctl_q.addr;
    assign mem_cs1_n = ctl_q.cs_n;
    assign mem_cs2_n = ctl_q.cs_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_dq_o  = ctl_q.wdata;
    assign mem_dq_oe = ctl_q.dq_oe;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W    = 14,
    parameter int PULSE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    logic [7:0] we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         we_run <= '0;
        else if (!mem_we_n) we_run <= we_run + 8'd1;
        else                we_run <= '0;
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_cs_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs1_n == mem_cs2_n);

    assert_no_fight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_oe_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs1_n && !mem_cs2_n));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

    assert_dq_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    assert_dq_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs1_n |-> !req_ready);

    assert_strobe_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == 8'(PULSE_CYC)));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2_n (mem_cs2_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sram_seq_ctrl;

    localparam int AW    = 6;
    localparam int DW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int CLKNS = 5;
    // Expected cycle counts from the requirements.
    localparam int SETUP_E = 1;
    localparam int RECOV_E = 1;
    localparam int ACC_E   = (20 + CLKNS - 1) / CLKNS;
    localparam int WP_E    = (17 + CLKNS - 1) / CLKNS;
    localparam int DWC_E   = (10 + CLKNS - 1) / CLKNS + 1;
    localparam int PULSE_E = (WP_E > DWC_E) ? ((WP_E < 2) ? 2 : WP_E) : ((DWC_E < 2) ? 2 : DWC_E);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int  nvec = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKNS)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2_n(mem_cs2_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model: data only valid after ACC_E-1 full selected cycles.
    logic [DW-1:0] ram [DEPTH];
    int            sel_cnt = 0;
    logic          rd_sel;
    assign rd_sel   = !mem_cs1_n && !mem_cs2_n && mem_we_n && !mem_oe_n;
    assign mem_dq_i = (rd_sel && sel_cnt >= ACC_E - 1) ? ram[mem_addr] : 'x;

    initial for (int i = 0; i < DEPTH; i++) ram[i] = '0;

    always @(posedge clk) begin
        sel_cnt <= rd_sel ? sel_cnt + 1 : 0;
        if (!mem_cs1_n && !mem_cs2_n && !mem_we_n && mem_dq_oe)
            ram[mem_addr] <= mem_dq_o;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Passive pin monitor, sampled away from the active edge.
    logic          p_we = 1'b1, p_oe = 1'b1, p_dq = 1'b0, p_cs = 1'b1;
    logic [AW-1:0] p_addr = '0;
    int            we_run = 0, oe_run = 0, dq_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 chip selects equal", {31'd0, mem_cs1_n}, {31'd0, mem_cs2_n});
            if (!mem_we_n) chk("R5 oe high in strobe", {31'd0, mem_oe_n}, 32'd1);
            if (!mem_cs1_n && !p_cs) chk("R6 addr stable while selected", 32'(mem_addr), 32'(p_addr));
            if (mem_dq_oe && !p_dq) chk("R7 dq starts after we fell", {30'd0, mem_we_n, p_we}, 32'd0);
            if (mem_dq_oe) chk("R3 no drive while oe low", {31'd0, mem_oe_n}, 32'd1);
            if (mem_we_n && !p_we) chk("R9 strobe length", 32'(we_run), 32'(PULSE_E));
            if (mem_oe_n && !p_oe) chk("R3 oe low window", 32'(oe_run), 32'(ACC_E));
            if (!mem_dq_oe && p_dq) chk("R7 drive window", 32'(dq_run), 32'(PULSE_E));
            we_run = mem_we_n ? 0 : we_run + 1;
            oe_run = mem_oe_n ? 0 : oe_run + 1;
            dq_run = mem_dq_oe ? dq_run + 1 : 0;
        end
        p_we = mem_we_n; p_oe = mem_oe_n; p_dq = mem_dq_oe; p_cs = mem_cs1_n; p_addr = mem_addr;
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat, output logic [DW-1:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        lat = 1;
        rd  = 'x;
        if (!wr) begin
            while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
            rd = rsp_rdata;
            @(negedge clk);
            chk("R4 rvalid single pulse", {31'd0, rsp_valid}, 32'd0);
        end else begin
            while (!req_ready && lat < 50) begin @(negedge clk); lat++; end
        end
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'((a * 5 + 3) & 15);
    endfunction
    function automatic logic [DW-1:0] pat2(input int a);
        return DW'(~(a ^ (a >> 2)) & 15);
    endfunction

    initial begin
        int            lat;
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        chk("R1 reset cs", {30'd0, mem_cs1_n, mem_cs2_n}, 32'd3);
        chk("R1 reset we/oe", {30'd0, mem_we_n, mem_oe_n}, 32'd3);
        chk("R1 reset dq_oe", {31'd0, mem_dq_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 idle pins", {27'd0, mem_cs1_n, mem_cs2_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h1E);

        // Sweep 1: ascending writes then ascending reads.
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b1, AW'(a), pat1(a), lat, rd);
            chk("R8 write latency", 32'(lat), 32'(SETUP_E + PULSE_E + RECOV_E + 1));
        end
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b0, AW'(a), '0, lat, rd);
            chk("R4 read latency", 32'(lat), 32'(SETUP_E + ACC_E + 1));
            chk("R10 read data sweep1", 32'(rd), 32'(pat1(a)));
        end
        // Sweep 2: descending writes, each followed by a read of the neighbour.
        for (int a = DEPTH - 1; a >= 0; a--) begin
            do_op(1'b1, AW'(a), pat2(a), lat, rd);
            do_op(1'b0, AW'((a + 1) % DEPTH), '0, lat, rd);
            chk("R3 read data interleaved", 32'(rd),
                32'((a == DEPTH - 1) ? pat1(0) : pat2(a + 1)));
        end
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b0, AW'(a), '0, lat, rd);
            chk("R10 read data sweep2", 32'(rd), 32'(pat2(a)));
        end
        @(negedge clk);
        chk("R1 idle at end", {27'd0, mem_cs1_n, mem_cs2_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h1E);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule